// File: doc/BRIEF.md
# Register Write-Protection Violation Monitor

This block sits beside the configuration registers of a serial peripheral and watches every write the register bus makes to them. It decides, access by access, whether a write may reach its target register. It also keeps a short record of three kinds of trouble, one sticky bit for each:
- a write that protection refused;
- a software reset requested while protection was armed;
- a configuration write made while the chip select it concerns was driving a transfer.

With the record it keeps the byte offset of the register that was last involved. Software reads that record through a read-only status word, and the read empties it. The key register that arms protection, and the serial datapath, are outside the block. The block takes the armed level and the per-chip-select activity flags as inputs.

Top module: `wpv_monitor`

## Requirements
- R1: While reset is asserted, and until the first event after it, `status_rdata` is all zeros and `wr_allow` is low.
- R2: The protected registers are the mode register (offset 0x04) and the chip-select configuration registers (offsets 0x30 + 4*i, i < NUM_CS). A write to one of them while `wp_on` is high drives `wr_allow` low in that cycle and sets type bit 0 on the next edge. Every other write drives `wr_allow` high, and `wr_allow` is low when `wr_en` is low.
- R3: `swrst` high while `wp_on` is high sets type bit 1 on the next edge. `swrst` with `wp_on` low changes nothing.
- R4: A write to the mode register, the interrupt-enable register (0x14), the interrupt-disable register (0x18) or any chip-select configuration register clears type bit 1, whether protection is on or off. Type bits 0 and 2 are not affected. A set and a clear in the same cycle leave the bit set.
- R5: A write to the mode register while any bit of `cs_act` is high sets type bit 2.
- R6: A write to chip-select configuration register i sets type bit 2 only when `cs_act[i]` is high. Activity on other chip selects has no effect.
- R7: The type bits hold until `rd_en` is pulsed. That cycle returns the current value and clears the bits. An event in the same cycle as the read is recorded again.
- R8: The register offset of the latest blocked or chip-select-conflict write is placed in `status_rdata[15:8]`. A read clears it unless such a write coincides with the read. A software-reset event leaves it unchanged.
- R9: `status_rdata[2:0]` is the type field: bit 0 is blocked write, bit 1 is reset while protected, bit 2 is write while selected. Bits 7:3 and 31:16 are always zero.
- R10: Chip-select configuration offsets at or beyond index NUM_CS are neither protected nor checked against `cs_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | One-cycle write strobe of a bus access |
| wr_addr | input | 8 | Byte offset of the write |
| rd_en | input | 1 | One-cycle read strobe of the status word |
| wp_on | input | 1 | Write protection armed |
| swrst | input | 1 | Software reset request strobe |
| cs_act | input | 4 | Per-chip-select transfer active flags |
| wr_allow | output | 1 | The current write may update its register |
| status_rdata | output | 32 | Status word: type bits 2:0, offset 15:8 |

## Verification
The hardest situations to reach from the ports are cycles where several rules meet at once. Examples are a blocked write that arrives in the same cycle as the status read, and a software reset that coincides with a write that would clear its own bit. The directed phase builds each of these with a single-cycle stimulus that drives the colliding strobes together. A long random phase then mixes protected, unprotected and out-of-range offsets with reads. It uses a biased address choice so that collisions recur often, and a behavioural model judges every cycle.

// File: rtl/wpv_pkg.sv
package wpv_pkg;

  // Bit positions of the type field in the status word
  localparam int unsigned TYPE_BLK = 0;
  localparam int unsigned TYPE_RST = 1;
  localparam int unsigned TYPE_CSW = 2;
  localparam int unsigned TYPE_W   = 3;

  typedef struct packed {
    logic csw;  // configuration write while selected
    logic rst;  // software reset under protection
    logic blk;  // write refused
  } wpv_evt_t;

endpackage

// File: rtl/wpv_addr_decode.sv
module wpv_addr_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CS   = 4,
  parameter logic [7:0]  MODE_OFS = 8'h04,
  parameter logic [7:0]  IER_OFS  = 8'h14,
  parameter logic [7:0]  IDR_OFS  = 8'h18,
  parameter logic [7:0]  CSR_BASE = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_mode,
  output logic              hit_ier,
  output logic              hit_idr,
  output logic              hit_csr,
  output logic [NUM_CS-1:0] csr_sel
);

  localparam int unsigned STRIDE = 4;

  assign hit_mode = (addr == ADDR_W'(MODE_OFS));
  assign hit_ier  = (addr == ADDR_W'(IER_OFS));
  assign hit_idr  = (addr == ADDR_W'(IDR_OFS));

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_csr
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CSR_BASE + gi * STRIDE);
    assign csr_sel[gi] = (addr == OFS);
  end

  assign hit_csr = |csr_sel;

  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_mode, hit_ier, hit_idr, csr_sel})) else $error("decode overlap"); // R10

endmodule

// File: rtl/wpv_event_gen.sv
module wpv_event_gen
  import wpv_pkg::*;
#(
  parameter int unsigned NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wp_on,
  input  logic              swrst,
  input  logic [NUM_CS-1:0] cs_act,
  input  logic              hit_mode,
  input  logic              hit_ier,
  input  logic              hit_idr,
  input  logic              hit_csr,
  input  logic [NUM_CS-1:0] csr_sel,
  output wpv_evt_t          evt,
  output logic              clr_rst,
  output logic              wr_allow
);

  logic prot_hit;
  logic sel_conflict;

  always_comb begin
    prot_hit     = hit_mode | hit_csr;
    sel_conflict = (hit_mode & (|cs_act)) | (|(csr_sel & cs_act));
    evt.blk      = wr_en & prot_hit & wp_on;
    evt.rst      = swrst & wp_on;
    evt.csw      = wr_en & sel_conflict;
    clr_rst      = wr_en & (prot_hit | hit_ier | hit_idr);
    wr_allow     = wr_en & ~(prot_hit & wp_on);
  end

  AST_BLOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    evt.blk |-> !wr_allow) else $error("blocked write allowed"); // R2

  AST_RST_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_on |-> !evt.rst) else $error("reset event without protection"); // R3

endmodule

// File: rtl/wpv_status_regs.sv
module wpv_status_regs
  import wpv_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SRC_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  wpv_evt_t          evt,
  input  logic              clr_rst,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] rdata
);

  logic [TYPE_W-1:0] type_q, type_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic              type_en, src_en;
  logic              src_evt;

  always_comb begin
    type_d = type_q;
    if (rd_en) type_d = '0;
    if (clr_rst) type_d[TYPE_RST] = 1'b0;
    if (evt.blk) type_d[TYPE_BLK] = 1'b1;
    if (evt.rst) type_d[TYPE_RST] = 1'b1;
    if (evt.csw) type_d[TYPE_CSW] = 1'b1;
    type_en = rd_en | clr_rst | (|evt);

    src_evt = evt.blk | evt.csw;
    src_d   = src_evt ? wr_addr : '0;
    src_en  = src_evt | rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      src_q  <= '0;
    end else begin
      if (type_en) type_q <= type_d;
      if (src_en)  src_q  <= src_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[TYPE_W-1:0]          = type_q;
    rdata[SRC_LSB +: ADDR_W]   = src_q;
  end

  AST_BLK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.blk |=> type_q[TYPE_BLK]) else $error("blocked write not recorded"); // R2

  AST_RST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rst |=> type_q[TYPE_RST]) else $error("reset event not recorded"); // R3

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rst && !evt.rst) |=> !type_q[TYPE_RST]) else $error("bit1 not cleared"); // R4

  AST_CSW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.csw |=> type_q[TYPE_CSW]) else $error("select conflict not recorded"); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && type_q[TYPE_BLK]) |=> type_q[TYPE_BLK]) else $error("bit0 lost"); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(|evt)) |=> (type_q == '0 && src_q == '0)) else $error("read did not clear"); // R7

  AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.blk || evt.csw) |=> (src_q == $past(wr_addr))) else $error("offset not captured"); // R8

endmodule

// File: rtl/wpv_monitor.sv
module wpv_monitor
  import wpv_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_CS   = 4,
  parameter int unsigned SRC_LSB  = 8,
  parameter logic [7:0]  MODE_OFS = 8'h04,
  parameter logic [7:0]  IER_OFS  = 8'h14,
  parameter logic [7:0]  IDR_OFS  = 8'h18,
  parameter logic [7:0]  CSR_BASE = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_en,
  input  logic              wp_on,
  input  logic              swrst,
  input  logic [NUM_CS-1:0] cs_act,
  output logic              wr_allow,
  output logic [DATA_W-1:0] status_rdata
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              hit_mode, hit_ier, hit_idr, hit_csr;
  logic [NUM_CS-1:0] csr_sel;
  wpv_evt_t          evt;
  logic              clr_rst;
  logic              allow_raw;

  wpv_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .MODE_OFS(MODE_OFS),
    .IER_OFS(IER_OFS), .IDR_OFS(IDR_OFS), .CSR_BASE(CSR_BASE)
  ) u_dec (
    .clk(clk), .rst_n(rst_int_n), .addr(wr_addr),
    .hit_mode(hit_mode), .hit_ier(hit_ier), .hit_idr(hit_idr),
    .hit_csr(hit_csr), .csr_sel(csr_sel)
  );

  wpv_event_gen #(.NUM_CS(NUM_CS)) u_evt (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_en & rst_int_n), .wp_on(wp_on), .swrst(swrst & rst_int_n),
    .cs_act(cs_act), .hit_mode(hit_mode), .hit_ier(hit_ier), .hit_idr(hit_idr),
    .hit_csr(hit_csr), .csr_sel(csr_sel),
    .evt(evt), .clr_rst(clr_rst), .wr_allow(allow_raw)
  );

  wpv_status_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_LSB(SRC_LSB)) u_st (
    .clk(clk), .rst_n(rst_int_n), .rd_en(rd_en & rst_int_n),
    .evt(evt), .clr_rst(clr_rst), .wr_addr(wr_addr), .rdata(status_rdata)
  );

  assign wr_allow = allow_raw;

  AST_MODE_GUARDED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wp_on && wr_addr == ADDR_W'(MODE_OFS)) |-> !wr_allow)
    else $error("protected mode write allowed"); // R2

  AST_IDLE_NO_ALLOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_en |-> !wr_allow) else $error("allow without write"); // R2

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status_rdata[7:3] == 5'd0 && status_rdata[31:16] == 16'd0))
    else $error("reserved bits set"); // R9

endmodule

// File: tb/wpv_monitor_bench.sv
`timescale 1ns/1ps
module wpv_monitor_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, wp_on, swrst;
  logic [7:0]  wr_addr;
  logic [3:0]  cs_act;
  logic        wr_allow;
  logic [31:0] status_rdata;

  int checks = 0;
  int failures = 0;

  // Behavioural reference state
  bit [2:0] m_type;
  bit [7:0] m_src;

  always #2.5 clk = ~clk;

  wpv_monitor u_wpv_monitor (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .wp_on(wp_on), .swrst(swrst), .cs_act(cs_act),
    .wr_allow(wr_allow), .status_rdata(status_rdata)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int csr_index(input bit [7:0] a);
    int k;
    if (a < 8'h30 || a[1:0] != 2'b00) return -1;
    k = (int'(a) - 'h30) / 4;
    return (k < 4) ? k : -1;
  endfunction

  function automatic bit [31:0] m_word();
    return {16'h0, m_src, 5'h0, m_type};
  endfunction

  task automatic idle();
    wr_en = 0; rd_en = 0; swrst = 0; wr_addr = 8'h00;
  endtask

  // One bus cycle: drive, compare, advance the reference model
  task automatic step(input bit w, input bit [7:0] a, input bit r, input bit wp,
                      input bit sr, input bit [3:0] cs, input string tag);
    bit prot, blk, csw, rst_ev, clr;
    int idx;
    @(negedge clk);
    wr_en = w; wr_addr = a; rd_en = r; wp_on = wp; swrst = sr; cs_act = cs;
    idx  = csr_index(a);
    prot = (a == 8'h04) || (idx >= 0);
    blk  = w && prot && wp;
    csw  = w && (((a == 8'h04) && (cs != 0)) || ((idx >= 0) && cs[idx]));
    rst_ev = sr && wp;
    clr  = w && (prot || a == 8'h14 || a == 8'h18);
    #1;
    chk({31'd0, wr_allow}, {31'd0, w && !(prot && wp)}, {tag, "/R2 allow"});
    chk(status_rdata, m_word(), {tag, "/R9 word"});
    @(posedge clk);
    if (r) begin m_type = 0; m_src = 0; end
    if (clr) m_type[1] = 0;
    if (blk) m_type[0] = 1;
    if (rst_ev) m_type[1] = 1;
    if (csw) m_type[2] = 1;
    if (blk || csw) m_src = a;
    #1;
    idle();
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_type = 0; m_src = 0;
    idle(); wp_on = 0; cs_act = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(status_rdata, 32'h0, "R1 status in reset");
    chk({31'd0, wr_allow}, 32'h0, "R1 allow in reset");
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(status_rdata, 32'h0, "R1 status after reset");

    // R2 protection
    step(1, 8'h04, 0, 0, 0, 4'h0, "R2 mode wp off");
    chk(status_rdata, 32'h0, "R2 no event wp off");
    step(1, 8'h04, 0, 1, 0, 4'h0, "R2 mode wp on");
    chk(status_rdata, 32'h0000_0401, "R8 blocked mode");
    step(0, 8'h00, 1, 1, 0, 4'h0, "R7 read");
    chk(status_rdata, 32'h0, "R7 cleared by read");
    step(1, 8'h14, 0, 1, 0, 4'h0, "R2 ier unprotected");
    chk(status_rdata, 32'h0, "R2 ier no event");

    // R3 / R4 software reset bit
    step(0, 8'h00, 0, 0, 1, 4'h0, "R3 swrst wp off");
    chk(status_rdata, 32'h0, "R3 ignored without wp");
    step(0, 8'h00, 0, 1, 1, 4'h0, "R3 swrst wp on");
    chk(status_rdata, 32'h0000_0002, "R3 bit1 set");
    for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 1, 0, 4'h0, "R7 hold");
    chk(status_rdata, 32'h0000_0002, "R7 bit1 sticky");
    step(1, 8'h18, 0, 1, 0, 4'h0, "R4 idr write");
    chk(status_rdata, 32'h0, "R4 idr clears bit1");
    step(0, 8'h00, 0, 1, 1, 4'h0, "R3 swrst again");
    step(1, 8'h20, 0, 1, 0, 4'h0, "R4 other offset");
    chk(status_rdata, 32'h0000_0002, "R4 unrelated keeps bit1");
    step(1, 8'h30, 0, 0, 0, 4'h0, "R4 csr write");
    chk(status_rdata, 32'h0, "R4 csr clears bit1");

    // R5 / R6 chip-select conflicts
    step(1, 8'h04, 0, 0, 0, 4'b0100, "R5 mode while selected");
    chk(status_rdata, 32'h0000_0404, "R5 bit2 set");
    step(0, 8'h00, 1, 0, 0, 4'h0, "R7 read");
    step(1, 8'h34, 0, 0, 0, 4'b0001, "R6 other cs");
    chk(status_rdata, 32'h0, "R6 other cs ignored");
    step(1, 8'h34, 0, 0, 0, 4'b0010, "R6 own cs");
    chk(status_rdata, 32'h0000_3404, "R6 bit2 for csr1");

    // R7 event coincident with read
    step(1, 8'h38, 1, 1, 0, 4'h0, "R7 read plus block");
    chk(status_rdata, 32'h0000_3801, "R7 coincident kept");

    // R10 out-of-range index
    step(1, 8'h40, 0, 1, 0, 4'hF, "R10 index 4");
    chk(status_rdata, 32'h0000_3801, "R10 no event");

    // R9 all causes together, then R4 selective clear
    step(0, 8'h00, 1, 0, 0, 4'h0, "R7 read");
    step(1, 8'h04, 0, 1, 1, 4'hF, "R9 all causes");
    chk(status_rdata, 32'h0000_0407, "R9 type 7");
    step(1, 8'h14, 0, 1, 0, 4'h0, "R4 ier clears only bit1");
    chk(status_rdata, 32'h0000_0405, "R4 bits 0 and 2 kept");

    // Random mix compared against the model every cycle
    for (int n = 0; n < 400; n++) begin
      bit [7:0] a;
      int pick = $urandom_range(0, 7);
      case (pick)
        0: a = 8'h04;
        1: a = 8'h14;
        2: a = 8'h18;
        3, 4: a = 8'h30 + 8'($urandom_range(0, 4) * 4);
        5: a = 8'($urandom_range(0, 255));
        default: a = 8'h04 + 8'($urandom_range(0, 3) * 4);
      endcase
      step($urandom_range(0, 3) != 0, a, $urandom_range(0, 5) == 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 6) == 0,
           4'($urandom_range(0, 15)), "R7 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule